// File: doc/BRIEF.md
# Thermal Burst Limiter

The block sits in series with a pulse path and keeps the average repetition rate low enough that the output stage cannot overheat. It receives the pulse level together with single-cycle strobes that mark the rising and the falling edge of each pulse. These strobes come from an upstream synchroniser. A heat accumulator estimates the temperature rise of the output stage. Every cycle in which a pulse is passed adds to it. It then cools by a step taken from a constant table. The table is indexed by the time elapsed since the most recent rising edge, so closely spaced pulses cool less than sparse ones.

A two-state controller either passes pulses or blocks them. It starts blocking when the accumulator reaches an upper threshold. It resumes passing only after the accumulator has fallen below a lower threshold. Each pulse whose rising edge arrives while the block is blocking is dropped for its whole width, and the drop is flagged by a single-cycle error. Two step tables, one for short and one for long output pulses, are parameters. An input selects between them.

Top module: `thermal_burst_limiter`

## Requirements
- R1: After reset, `limiting_o` is 0, the accumulator is 0 and `pulse_o` and `drop_err_o` are 0, so the first incoming pulse is passed.
- R2: While `limiting_o` is 0, a pulse whose rising strobe arrives in the passing state appears on `pulse_o` cycle for cycle, starting on the same cycle as its rising strobe.
- R3: While `limiting_o` is 1, `pulse_o` is 0. A pulse that is being passed when limiting starts is cut off in the first limiting cycle.
- R4: `drop_err_o` is high for exactly the one cycle in which a rising strobe arrives while `limiting_o` is 1, and it is never high at any other time.
- R5: A pulse whose rising strobe arrives during limiting stays fully blocked until its falling strobe, even if limiting ends before then. The next pulse after limiting has ended is passed.
- R6: Each cycle, the accumulator adds HEAT_INC if `pulse_o` is high. It then subtracts the table step at index min(cycles since the last rising strobe >> BIN_SHIFT, N_STEPS-1), and it saturates at 0. It never grows by more than HEAT_INC per cycle and never grows on a cycle without output. Sparse pulses, such as 4 high cycles every 64 cycles with the default parameters, never cause limiting.
- R7: Limiting starts only when the accumulator is at or above THR_HI. It ends only when the accumulator is below THR_LO. With the default parameters and no input, limiting therefore lasts at least 120 cycles.
- R8: For the same pulse width, a higher repetition rate reaches limiting in fewer cycles from reset than a lower rate does.
- R9: `long_mode_i` = 1 selects the long-pulse step table. With the default tables, it reaches limiting sooner than the short table for the same pulse train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| long_mode_i | input | 1 | 1 selects the long-pulse step table, 0 selects the short-pulse table |
| pulse_i | input | 1 | Incoming pulse level |
| rise_p_i | input | 1 | Single-cycle strobe marking the rising edge of pulse_i |
| fall_p_i | input | 1 | Single-cycle strobe marking the falling edge of pulse_i |
| pulse_o | output | 1 | Gated pulse: a copy of pulse_i, or held at 0 |
| limiting_o | output | 1 | 1 while the block is in the blocking state |
| drop_err_o | output | 1 | Single-cycle flag for each dropped pulse |

## Verification
The block is driven with pulse trains of 4 high cycles and periods of 8, 24 and 64 cycles, in both table modes.
- The 64-cycle train separates correct cooling from a stuck or missing decrement, because it must never cause limiting.
- The 8-cycle and 24-cycle trains measure the time to reach limiting. This confirms that the step depends on the repetition rate, and that the long table heats faster than the short one.
- A train that stops right after limiting begins, followed by one very long pulse, shows three things:
  - the truncation of the pulse in progress;
  - the hysteresis hold time;
  - that a pulse which starts during limiting stays blocked even after limiting ends.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  typedef enum logic {
    ST_PASS  = 1'b0,
    ST_BLOCK = 1'b1
  } lim_state_e;
endpackage

// File: rtl/tbl_period_meter.sv
module tbl_period_meter #(
  parameter int PER_W     = 10,
  parameter int BIN_SHIFT = 4,
  parameter int N_STEPS   = 4,
  parameter int STEP_W    = 8,
  parameter logic [N_STEPS-1:0][STEP_W-1:0] STEPS_SHORT = {8'd8, 8'd4, 8'd2, 8'd1},
  parameter logic [N_STEPS-1:0][STEP_W-1:0] STEPS_LONG  = {8'd2, 8'd1, 8'd1, 8'd1}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              long_i,
  output logic [STEP_W-1:0] step_o
);
  localparam int IDX_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
  localparam logic [PER_W-1:0] CNT_MAX = '1;

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] bin;
  logic [IDX_W-1:0] idx;

  // counts cycles since the last rising strobe; out of reset it reads as "long ago"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= CNT_MAX;
    else if (rise_i)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    bin = cnt_q >> BIN_SHIFT;
    if (bin > PER_W'(N_STEPS - 1)) idx = IDX_W'(N_STEPS - 1);
    else                           idx = bin[IDX_W-1:0];
    step_o = long_i ? STEPS_LONG[idx] : STEPS_SHORT[idx];
  end
endmodule

// File: rtl/tbl_heat_accum.sv
module tbl_heat_accum #(
  parameter int HEAT_W   = 16,
  parameter int STEP_W   = 8,
  parameter int HEAT_INC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [HEAT_W-1:0] heat_o
);
  localparam int SUM_W = HEAT_W + 1;

  logic [HEAT_W-1:0] heat_q, heat_d;
  logic [SUM_W-1:0]  sum, diff;

  always_comb begin
    sum  = {1'b0, heat_q} + (inc_i ? SUM_W'(HEAT_INC) : '0);
    diff = sum - SUM_W'(step_i);
    if (sum <= SUM_W'(step_i)) heat_d = '0;
    else if (diff[HEAT_W])     heat_d = '1;
    else                       heat_d = diff[HEAT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) heat_q <= '0;
    else         heat_q <= heat_d;
  end

  assign heat_o = heat_q;

  assert_heat_growth_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({1'b0, heat_q} <= {1'b0, $past(heat_q)} + SUM_W'(HEAT_INC)));
  assert_no_idle_heat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> (heat_q <= $past(heat_q)));
endmodule

// File: rtl/tbl_gate_fsm.sv
module tbl_gate_fsm
  import tbl_pkg::*;
#(
  parameter int HEAT_W = 16,
  parameter int THR_HI = 2000,
  parameter int THR_LO = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [HEAT_W-1:0] heat_i,
  output logic              open_o,
  output logic              block_o,
  output logic              drop_o
);
  lim_state_e state_q, state_d;
  logic       pass_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PASS:  if (heat_i >= HEAT_W'(THR_HI)) state_d = ST_BLOCK;
      ST_BLOCK: if (heat_i <  HEAT_W'(THR_LO)) state_d = ST_PASS;
      default:  state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PASS;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // admission is decided once per pulse, at its rising strobe
      if (state_q == ST_BLOCK) pass_q <= 1'b0;
      else if (rise_i)         pass_q <= 1'b1;
      else if (fall_i)         pass_q <= 1'b0;
    end
  end

  assign block_o = (state_q == ST_BLOCK);
  assign open_o  = !block_o && (rise_i || pass_q);
  assign drop_o  = block_o && rise_i;

  assert_enter_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(block_o) |-> ($past(heat_i) >= HEAT_W'(THR_HI)));
  assert_exit_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(block_o) |-> ($past(heat_i) < HEAT_W'(THR_LO)));
endmodule

// File: rtl/thermal_burst_limiter.sv
module thermal_burst_limiter #(
  parameter int HEAT_W    = 16,
  parameter int HEAT_INC  = 16,
  parameter int THR_HI    = 2000,
  parameter int THR_LO    = 1000,
  parameter int PER_W     = 10,
  parameter int BIN_SHIFT = 4,
  parameter int N_STEPS   = 4,
  parameter int STEP_W    = 8,
  parameter logic [N_STEPS-1:0][STEP_W-1:0] STEPS_SHORT = {8'd8, 8'd4, 8'd2, 8'd1},
  parameter logic [N_STEPS-1:0][STEP_W-1:0] STEPS_LONG  = {8'd2, 8'd1, 8'd1, 8'd1}
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_mode_i,
  input  logic pulse_i,
  input  logic rise_p_i,
  input  logic fall_p_i,
  output logic pulse_o,
  output logic limiting_o,
  output logic drop_err_o
);
  logic [STEP_W-1:0] step;
  logic [HEAT_W-1:0] heat;
  logic              gate_open;

  tbl_period_meter #(
    .PER_W(PER_W), .BIN_SHIFT(BIN_SHIFT), .N_STEPS(N_STEPS), .STEP_W(STEP_W),
    .STEPS_SHORT(STEPS_SHORT), .STEPS_LONG(STEPS_LONG)
  ) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise_p_i), .long_i(long_mode_i), .step_o(step)
  );

  tbl_heat_accum #(.HEAT_W(HEAT_W), .STEP_W(STEP_W), .HEAT_INC(HEAT_INC)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pulse_o), .step_i(step), .heat_o(heat)
  );

  tbl_gate_fsm #(.HEAT_W(HEAT_W), .THR_HI(THR_HI), .THR_LO(THR_LO)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise_p_i), .fall_i(fall_p_i), .heat_i(heat),
    .open_o(gate_open), .block_o(limiting_o), .drop_o(drop_err_o)
  );

  // output mux: copy or force low
  assign pulse_o = gate_open ? pulse_i : 1'b0;

  assert_block_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limiting_o |-> !pulse_o);
  assert_drop_only_limiting_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_err_o |-> (limiting_o && rise_p_i && !pulse_o));
  assert_drop_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_err_o |=> !drop_err_o);
endmodule

// File: tb/thermal_burst_limiter_bench.sv
module thermal_burst_limiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic long_mode = 1'b0, pulse = 1'b0, rise = 1'b0, fall = 1'b0;
  logic pulse_o, limiting_o, drop_err_o;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int mon_fail = 0, hi_cnt = 0, err_cnt = 0;
  bit bpass = 1'b0, prev_lim = 1'b0, seen_rej = 1'b0, fell_seen = 1'b0, mon_on = 1'b0;
  int rej_start = 0, rej_end = 0;
  bit done = 1'b0;

  thermal_burst_limiter u_thermal_burst_limiter (
    .clk_i(clk), .rst_ni(rst_n), .long_mode_i(long_mode), .pulse_i(pulse),
    .rise_p_i(rise), .fall_p_i(fall), .pulse_o(pulse_o), .limiting_o(limiting_o),
    .drop_err_o(drop_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle expectation from R2/R3/R4
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_o, exp_e;
      exp_o = pulse && !limiting_o && (rise || bpass);
      exp_e = rise && limiting_o;
      if (pulse_o !== exp_o) begin
        mon_fail++;
        $display("FAIL R2/R3 cyc %0d: pulse_o=%0b expected %0b", cyc, pulse_o, exp_o);
      end
      if (drop_err_o !== exp_e) begin
        mon_fail++;
        $display("FAIL R4 cyc %0d: drop_err_o=%0b expected %0b", cyc, drop_err_o, exp_e);
      end
      if (pulse_o) hi_cnt++;
      if (drop_err_o) err_cnt++;
      if (limiting_o && !prev_lim) begin seen_rej = 1'b1; rej_start = cyc; end
      if (!limiting_o && prev_lim) begin fell_seen = 1'b1; rej_end = cyc; end
      prev_lim = limiting_o;
      if (limiting_o) bpass = 1'b0;
      else if (rise) bpass = 1'b1;
      else if (fall) bpass = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit lm);
    mon_on = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b0; pulse = 0; rise = 0; fall = 0; long_mode = lm;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    bpass = 0; prev_lim = 0; seen_rej = 0; fell_seen = 0;
    mon_fail = 0; hi_cnt = 0; err_cnt = 0;
    mon_on = 1'b1;
  endtask

  // width high cycles, then low for gap cycles; strobes aligned with level changes
  task automatic send_pulse(input int width, input int gap);
    @(posedge clk); #1;
    pulse = 1; rise = 1;
    for (int i = 1; i < width; i++) begin @(posedge clk); #1; rise = 0; end
    @(posedge clk); #1;
    rise = 0; pulse = 0; fall = 1;
    @(posedge clk); #1; fall = 0;
    for (int i = 2; i < gap; i++) @(posedge clk);
  endtask

  task automatic run_until_reject(input int width, input int period, input int maxp, output int t);
    int t0;
    t0 = cyc;
    t = -1;
    for (int p = 0; p < maxp; p++) begin
      send_pulse(width, period - width);
      if (seen_rej) begin t = rej_start - t0; break; end
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    @(negedge clk);
    chk(limiting_o == 0, "R1 limiting after reset", limiting_o, 0);
    chk(pulse_o == 0 && drop_err_o == 0, "R1 outputs after reset", {pulse_o, drop_err_o}, 0);
    send_pulse(4, 60);
    chk(hi_cnt == 4, "R1 first pulse passed", hi_cnt, 4);
  endtask

  task automatic t_pass;
    do_reset(1'b0);
    send_pulse(3, 61); send_pulse(7, 57); send_pulse(1, 63); send_pulse(5, 59);
    chk(hi_cnt == 16, "R2 passed high cycles", hi_cnt, 16);
    chk(mon_fail == 0, "R2 cycle-exact copy", mon_fail, 0);
  endtask

  task automatic t_low_rate;
    int t;
    do_reset(1'b0);
    run_until_reject(4, 64, 60, t);
    chk(!seen_rej, "R6 sparse train never limits", seen_rej, 0);
    chk(err_cnt == 0, "R4 no drop flags while passing", err_cnt, 0);
  endtask

  task automatic t_rate_mode;
    int ta, tb, tl;
    do_reset(1'b0); run_until_reject(4, 8, 400, ta);
    do_reset(1'b0); run_until_reject(4, 24, 400, tb);
    do_reset(1'b1); run_until_reject(4, 24, 400, tl);
    chk(ta > 0 && tb > 0, "R8 both rates reach limiting", ta, tb);
    chk(ta < tb, "R8 faster rate limits sooner", ta, tb);
    chk(tl > 0 && tl < tb, "R9 long table limits sooner", tl, tb);
    chk(mon_fail == 0, "R3 truncation at limiting entry", mon_fail, 0);
  endtask

  task automatic t_reject;
    int t, hi_before;
    do_reset(1'b0);
    run_until_reject(4, 8, 400, t);
    chk(t > 0, "R3 limiting reached", t, 1);
    hi_before = hi_cnt;
    err_cnt = 0;
    send_pulse(600, 20);
    chk(err_cnt == 1, "R4 one drop flag for dropped pulse", err_cnt, 1);
    chk(hi_cnt == hi_before, "R5 dropped pulse stays blocked", hi_cnt - hi_before, 0);
    chk(fell_seen, "R5 limiting ended during dropped pulse", fell_seen, 1);
    chk(fell_seen && (rej_end - rej_start) >= 120, "R7 hysteresis hold", rej_end - rej_start, 120);
    hi_before = hi_cnt;
    send_pulse(4, 40);
    chk(hi_cnt - hi_before == 4, "R5 next pulse passes", hi_cnt - hi_before, 4);
    chk(mon_fail == 0, "R3 cycle checks in limiting", mon_fail, 0);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_low_rate();
    t_rate_mode();
    t_reject();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 cycles over", MAX_CYC);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule